// File: doc/BRIEF.md
# Token-Ring Depth-Expansion FIFO Slice

This block is a FIFO slice built to be chained with identical slices into a ring, so that several small buffers act as one deeper FIFO. Every slice in the ring sees the same write strobe, write data and read strobe. Ownership moves around the ring through two tokens. The write token marks the slice that will take the next word. The read token marks the slice that holds the oldest word. A slice only accepts writes while it owns the write token, and only produces read data while it owns the read token.

When a slice writes its highest physical location, it raises a one-cycle write-expansion pulse and gives up the write token. When it reads its highest location, it does the same on a separate read-expansion pulse. The next slice in the ring takes the token on that same clock edge and starts at its location zero. Because the two pulses are separate wires, both tokens can move in one cycle. After reset, only the slice whose first-load input is high owns the tokens.

Each slice reports its own full and empty flags. A combining stage forms the system flags: the ring is full only when every slice is full, and empty only when every slice is empty. The same stage merges the read data of the slices. The top level wires a parameterised number of slices into a ring together with this combining stage.

Top module: `tokfifo_chain`

## Requirements
- R1: While reset is high and on the first cycle after it, `empty` is 1, `full` is 0 and `rd_valid` is 0. Slice 0 (the first-load slice) owns both tokens; every other slice owns neither.
- R2: Words leave the ring in the order they were accepted. This includes words that cross from one slice to the next and words that wrap from the last slice back to slice 0, and no accepted word is lost or duplicated.
- R3: `full` is 1 exactly when NUM_SLICES*SLICE_DEPTH words are stored. `empty` is 1 exactly when no word is stored. Both flags reflect the writes and reads accepted at the preceding clock edge.
- R4: A write strobe seen while `full` is 1 is ignored. No stored word is changed, and the later read order is unaffected.
- R5: A read strobe seen while `empty` is 1 is ignored. `rd_valid` stays 0 on the following cycle.
- R6: An accepted read makes `rd_valid` equal 1 on the next cycle, with the word on `rd_data`. `rd_valid` is 0 in every other cycle, and at most one slice drives data in any cycle.
- R7: A slice that writes its highest location pulses its write-expansion output for one cycle and loses the write token. The next slice in the ring owns the write token from the same edge, starting at location 0. The same hand-off rule applies to the read token on the read-expansion output.
- R8: Exactly one slice owns the write token and exactly one slice owns the read token at all times after reset.
- R9: A write and a read in the same cycle are both accepted when the ring is neither full nor empty. When full, only the read is accepted. When empty, only the write is accepted. The decision is based on the flags before the edge.
- R10: A slice that does not own a token ignores the matching strobe. Its pointer for that token does not move, and its occupancy does not change because of that strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe shared by all slices |
| wr_data | input | WIDTH | Word to be written |
| rd_en | input | 1 | Read strobe shared by all slices |
| rd_data | output | WIDTH | Word read, valid when `rd_valid` is 1 |
| rd_valid | output | 1 | High one cycle after an accepted read |
| full | output | 1 | All slices full |
| empty | output | 1 | All slices empty |

## Verification
The bench builds the ring with four slices of depth 16 and 9-bit words. With these values, filling the ring to 64 words takes only a few dozen cycles, so the write token completes a full lap and returns to a full slice 0. The bench also makes both tokens cross every slice boundary, and wrap around the ring, many times during the mixed and streaming phases. The small depth puts the corner cases within easy reach: writes while full, reads while empty, and simultaneous strobes at both extremes.

// File: rtl/tokfifo_pkg.sv
package tokfifo_pkg;

    // Occupancy flags reported by one slice.
    typedef struct packed {
        logic full;
        logic empty;
    } occ_flags_t;

    // Ownership state of one token cursor.
    typedef enum logic {
        CUR_IDLE = 1'b0,
        CUR_OWN  = 1'b1
    } cursor_e;

    // Index of the ring neighbour that feeds slice idx.
    function automatic int ring_prev(input int idx, input int n);
        return (idx + n - 1) % n;
    endfunction

endpackage

// File: rtl/tokfifo_cursor.sv
// One token holder plus the location pointer that travels with it.
module tokfifo_cursor
    import tokfifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          first_load,
    input  logic          xi,
    input  logic          step,
    output logic          own,
    output logic [PW-1:0] ptr,
    output logic          xo
);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    cursor_e st_q, st_d;

    assign own = (st_q == CUR_OWN);
    assign xo  = step && own && (ptr == LAST);

    always_comb begin
        st_d = st_q;
        if (xo) st_d = CUR_IDLE;
        if (xi) st_d = CUR_OWN;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= first_load ? CUR_OWN : CUR_IDLE;
            ptr  <= '0;
        end else begin
            st_q <= st_d;
            if (step && own) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

    // R10: a cursor without its token keeps its pointer still
    p_ptr_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        !own |=> $stable(ptr));
    // R7: after handing the token on, the cursor is idle and back at location 0
    p_hand_off_r7: assert property (@(posedge clk) disable iff (rst)
        (xo && !xi) |=> (!own && ptr == '0));
    // R7: an incoming token always lands on location 0
    p_enter_first_r7: assert property (@(posedge clk) disable iff (rst)
        (xi && !own) |-> (ptr == '0));

endmodule

// File: rtl/tokfifo_store.sv
// Storage array with one write port and a registered read port.
module tokfifo_store #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata,
    output logic             rvalid
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= re;
            if (re) rdata <= mem[raddr];
        end
    end

    // R6: read data appears exactly one cycle after the read request
    p_read_latency_r6: assert property (@(posedge clk) disable iff (rst)
        re |=> rvalid);

endmodule

// File: rtl/tokfifo_slice.sv
// One slice of the ring: storage, two token cursors and occupancy.
module tokfifo_slice
    import tokfifo_pkg::*;
#(
    parameter int WIDTH = 9,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             first_load,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic             xi_wr,
    input  logic             xi_rd,
    output logic             xo_wr,
    output logic             xo_rd,
    output occ_flags_t       flags,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_valid,
    output logic             wr_own,
    output logic             rd_own
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] CAP = CW'(DEPTH);

    logic [CW-1:0] count_q;
    logic [AW-1:0] wptr, rptr;
    logic          wr_fire, rd_fire;

    assign flags.full  = (count_q == CAP);
    assign flags.empty = (count_q == '0);
    assign wr_fire     = wr_en && wr_own && !flags.full;
    assign rd_fire     = rd_en && rd_own && !flags.empty;

    tokfifo_cursor #(.DEPTH(DEPTH)) u_wcur (
        .clk(clk), .rst(rst), .first_load(first_load), .xi(xi_wr),
        .step(wr_fire), .own(wr_own), .ptr(wptr), .xo(xo_wr)
    );

    tokfifo_cursor #(.DEPTH(DEPTH)) u_rcur (
        .clk(clk), .rst(rst), .first_load(first_load), .xi(xi_rd),
        .step(rd_fire), .own(rd_own), .ptr(rptr), .xo(xo_rd)
    );

    tokfifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst),
        .we(wr_fire), .waddr(wptr), .wdata(wr_data),
        .re(rd_fire), .raddr(rptr), .rdata(rd_data), .rvalid(rd_valid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else begin
            case ({wr_fire, rd_fire})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    // R9: a write alone raises occupancy by one
    p_write_grows_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_fire && !rd_fire) |=> (count_q == $past(count_q) + 1'b1));
    // R9: a paired write and read leave occupancy unchanged
    p_pair_balanced_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_fire && rd_fire) |=> $stable(count_q));
    // R10: strobes reaching a slice with no token leave occupancy alone
    p_idle_slice_r10: assert property (@(posedge clk) disable iff (rst)
        (!wr_own && !rd_own) |=> $stable(count_q));
    // R4: a full slice never overwrites a stored word
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        flags.full |=> (count_q <= CAP));

endmodule

// File: rtl/tokfifo_merge.sv
// Composite flags and read-data merge across all slices.
module tokfifo_merge #(
    parameter int WIDTH = 9,
    parameter int NUM   = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM-1:0]       full_v,
    input  logic [NUM-1:0]       empty_v,
    input  logic [NUM-1:0]       valid_v,
    input  logic [NUM*WIDTH-1:0] data_v,
    output logic                 full,
    output logic                 empty,
    output logic                 rd_valid,
    output logic [WIDTH-1:0]     rd_data
);
    assign full     = &full_v;
    assign empty    = &empty_v;
    assign rd_valid = |valid_v;

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM; i++) begin
            if (valid_v[i]) rd_data = rd_data | data_v[i*WIDTH +: WIDTH];
        end
    end

    // R6: at most one slice presents read data in a cycle
    p_single_source_r6: assert property (@(posedge clk) disable iff (rst)
        $countones(valid_v) <= 1);
    // R3: the ring cannot be full and empty at once
    p_flags_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));

endmodule

// File: rtl/tokfifo_chain.sv
// Ring of token-passing FIFO slices with composite flags.
module tokfifo_chain
    import tokfifo_pkg::*;
#(
    parameter int WIDTH       = 9,
    parameter int SLICE_DEPTH = 16,
    parameter int NUM_SLICES  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_valid,
    output logic             full,
    output logic             empty
);
    localparam int DW = NUM_SLICES * WIDTH;

    logic [NUM_SLICES-1:0] xo_wr_v, xo_rd_v;
    logic [NUM_SLICES-1:0] full_v, empty_v, valid_v;
    logic [NUM_SLICES-1:0] wown_v, rown_v;
    logic [DW-1:0]         data_v;

    for (genvar gi = 0; gi < NUM_SLICES; gi++) begin : g_slice
        localparam int PREV = ring_prev(gi, NUM_SLICES);
        occ_flags_t       fl;
        logic [WIDTH-1:0] sdata;

        tokfifo_slice #(.WIDTH(WIDTH), .DEPTH(SLICE_DEPTH)) u_slice (
            .clk(clk), .rst(rst),
            .first_load(gi == 0),
            .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
            .xi_wr(xo_wr_v[PREV]), .xi_rd(xo_rd_v[PREV]),
            .xo_wr(xo_wr_v[gi]), .xo_rd(xo_rd_v[gi]),
            .flags(fl), .rd_data(sdata), .rd_valid(valid_v[gi]),
            .wr_own(wown_v[gi]), .rd_own(rown_v[gi])
        );

        assign full_v[gi]                   = fl.full;
        assign empty_v[gi]                  = fl.empty;
        assign data_v[gi*WIDTH +: WIDTH]    = sdata;
    end

    tokfifo_merge #(.WIDTH(WIDTH), .NUM(NUM_SLICES)) u_merge (
        .clk(clk), .rst(rst),
        .full_v(full_v), .empty_v(empty_v), .valid_v(valid_v), .data_v(data_v),
        .full(full), .empty(empty), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    // R8: exactly one write-token owner
    p_one_wr_token_r8: assert property (@(posedge clk) disable iff (rst)
        $countones(wown_v) == 1);
    // R8: exactly one read-token owner
    p_one_rd_token_r8: assert property (@(posedge clk) disable iff (rst)
        $countones(rown_v) == 1);
    // R5: a read against an empty ring yields no data
    p_empty_read_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_en && empty) |=> !rd_valid);
    // R6: an accepted read is followed by valid data
    p_read_served_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !empty) |=> rd_valid);
    // R7: at most one write hand-off and one read hand-off per cycle
    p_single_handoff_r7: assert property (@(posedge clk) disable iff (rst)
        ($countones(xo_wr_v) <= 1) && ($countones(xo_rd_v) <= 1));

endmodule

// File: tb/tokfifo_chain_tb_top.sv
module tokfifo_chain_tb_top;
    localparam int W   = 9;
    localparam int D   = 16;
    localparam int N   = 4;
    localparam int CAP = N * D;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         rd_en = 1'b0;
    logic [W-1:0] rd_data;
    logic         rd_valid;
    logic         full, empty;

    int n_checks = 0;
    int n_fail   = 0;
    int mdl_count = 0;
    bit finished = 1'b0;
    logic [W-1:0] exp_q[$];
    logic [15:0]  lf = 16'hACE1;

    always #2 clk = ~clk;

    tokfifo_chain #(.WIDTH(W), .SLICE_DEPTH(D), .NUM_SLICES(N)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .rd_valid(rd_valid), .full(full), .empty(empty)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] lfsr_next(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    // Driver: one cycle of stimulus, model update, then flag and valid checks.
    task automatic step(input logic we, input logic [W-1:0] wd, input logic re, input string tag);
        bit acc_w, acc_r;
        acc_w = we && (mdl_count < CAP);
        acc_r = re && (mdl_count > 0);
        wr_en = we; wr_data = wd; rd_en = re;
        if (acc_w) exp_q.push_back(wd);
        mdl_count = mdl_count + int'(acc_w) - int'(acc_r);
        @(posedge clk); #1;
        wr_en = 1'b0; rd_en = 1'b0;
        check(rd_valid == acc_r, {"R6 rd_valid ", tag}, rd_valid, acc_r);
        check(full == (mdl_count == CAP), {"R3 full ", tag}, full, mdl_count == CAP);
        check(empty == (mdl_count == 0), {"R3 empty ", tag}, empty, mdl_count == 0);
    endtask

    // Monitor: compare every delivered word against the scoreboard queue.
    always @(posedge clk) begin
        #1;
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected word", int'(rd_data), -1);
            end else begin
                logic [W-1:0] e;
                e = exp_q.pop_front();
                check(rd_data == e, "R2/R7/R8/R10 order", int'(rd_data), int'(e));
            end
        end
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            check(1'b0, "watchdog", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(empty == 1'b1, "R1 empty in reset", empty, 1);
        check(full == 1'b0, "R1 full in reset", full, 0);
        check(rd_valid == 1'b0, "R1 rd_valid in reset", rd_valid, 0);
        rst = 1'b0;
        @(posedge clk); #1;
        check(empty == 1'b1 && full == 1'b0 && rd_valid == 1'b0, "R1 after reset",
              {full, empty, rd_valid}, 3'b010);

        // R5: reads on an empty ring
        for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b1, "R5 read-empty");

        // Fill all slices: write token crosses every boundary and laps (R7)
        for (int i = 0; i < CAP; i++) step(1'b1, W'(i * 7 + 3), 1'b0, "R7 fill");

        // R4: writes while full are dropped
        for (int i = 0; i < 3; i++) step(1'b1, W'(9'h1AA + i), 1'b0, "R4 write-full");

        // R9: paired strobes while full: only the read is taken
        step(1'b1, 9'h155, 1'b1, "R9 pair-at-full");

        // Drain: read token crosses every boundary (R7/R8)
        while (mdl_count > 0) step(1'b0, '0, 1'b1, "R7/R8 drain");
        step(1'b0, '0, 1'b0, "R2 settle");

        // R9: paired strobes while empty: only the write is taken
        step(1'b1, 9'h0F0, 1'b1, "R9 pair-at-empty");
        step(1'b0, '0, 1'b1, "R9 pop");

        // Mixed random traffic, many laps of both tokens
        for (int i = 0; i < 3000; i++) begin
            lf = lfsr_next(lf);
            step(lf[0] | lf[1], lf[12:4], lf[2] & (lf[3] | lf[5]), "R2/R9 mixed");
        end
        // Read-heavy phase to revisit the empty boundary
        for (int i = 0; i < 600; i++) begin
            lf = lfsr_next(lf);
            step(lf[0] & lf[1], lf[13:5], lf[2] | lf[3], "R5/R9 read-heavy");
        end
        // Streaming at mid occupancy: both strobes every cycle
        for (int i = 0; i < 30; i++) step(1'b1, W'(i + 100), 1'b0, "R9 prefill");
        for (int i = 0; i < 300; i++) step(1'b1, W'(i * 3), 1'b1, "R9 stream");

        while (mdl_count > 0) step(1'b0, '0, 1'b1, "R2 final drain");
        step(1'b0, '0, 1'b0, "R2 settle");
        check(exp_q.size() == 0, "R2 all words delivered", exp_q.size(), 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule